// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Byte

This block performs the arithmetic for a small accumulator-based 8-bit controller. Each request supplies an opcode, the accumulator, the B register, an immediate byte and the current status byte. One clock later the block returns the new accumulator, the new B register and the new status byte. It covers five operations: plain add, add with the incoming carry, subtract with the incoming borrow, unsigned multiply and unsigned divide.

For add and subtract, the second operand is either B or the immediate byte. Multiply and divide always work on the accumulator and B, and they spread their two-byte result over both registers. The status byte holds the carry, half-carry, overflow and parity flags. The software-owned bits (user flag, two bank-select bits and the spare bit) pass through untouched. The sequencer that owns the registers takes the three outputs when the valid strobe is high and writes them back.

Status byte layout, bit 7 down to bit 0: carry, half-carry, user flag, bank select high, bank select low, overflow, spare, parity. Opcodes are 0 add, 1 add with carry, 2 subtract with borrow, 3 multiply and 4 divide. Codes 5 to 7 are reserved.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 writes A + operand (mod 256) to A. Carry (bit 7) is set exactly when the unsigned sum exceeds 255. B is unchanged.
- R2: Opcode 1 behaves as opcode 0 but also adds the incoming carry bit (status bit 7) to the sum.
- R3: Opcode 2 writes A − operand − incoming carry (mod 256) to A. Carry is set exactly when that difference is negative as unsigned numbers. B is unchanged.
- R4: For opcodes 0 to 2, half-carry (bit 6) is set exactly when the low-nibble sum exceeds 15 (add) or the low-nibble difference is negative (subtract), counting the carry-in.
- R5: For opcodes 0 to 2, overflow (bit 2) is set exactly when the same operation on two's-complement operands gives a true result outside −128..+127.
- R6: For opcodes 0 to 4, parity (bit 0) equals 1 exactly when the new A holds an odd number of ones.
- R7: Opcode 3 forms A×B unsigned, with the high byte written to B and the low byte to A. Carry is cleared, and overflow is set exactly when the product exceeds 255.
- R8: Opcode 4 with nonzero B writes the quotient A/B to A and the remainder to B, and clears both carry and overflow.
- R9: Opcode 4 with B equal to zero leaves A and B unchanged, sets overflow and clears carry.
- R10: Status bits 5, 4, 3 and 1 are copied from the input for every opcode. Half-carry is copied unchanged for opcodes 3 and 4.
- R11: use_imm set selects the immediate byte as operand for opcodes 0 to 2. It has no effect on opcodes 3 and 4.
- R12: out_valid is high in the cycle after a cycle with in_valid high, and low otherwise. The outputs are held while in_valid is low. After reset all outputs are zero.
- R13: Reserved opcodes 5 to 7 return A, B and the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; inputs sampled this edge |
| op | input | 3 | Operation code |
| use_imm | input | 1 | Select immediate as add/subtract operand |
| acc_in | input | 8 | Current accumulator |
| b_in | input | 8 | Current B register |
| imm_in | input | 8 | Immediate operand |
| psw_in | input | 8 | Current status byte |
| out_valid | output | 1 | Result strobe |
| acc_out | output | 8 | New accumulator |
| b_out | output | 8 | New B register |
| psw_out | output | 8 | New status byte |

## Verification
Random bytes almost never produce the rarest flag mixes: a half-carry without a full carry while subtracting with an incoming borrow, a divide by zero, and a multiply whose product lands exactly on 255 or 256. The bench draws operands from $urandom with a fixed seed, and a quarter of the time it forces B to zero or to small values so that divide-by-zero and overflow boundaries come up often. Directed cases then hit 0x7F+1, 0x80−1, 0x0F+1 with carry-in, 15×17, 16×16 and 255×255 exactly.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUBB = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4
    } alu_op_e;

    // status byte bit positions; neighbours decode these
    localparam int ST_CY  = 7;
    localparam int ST_HC  = 6;
    localparam int ST_OV  = 2;
    localparam int ST_PAR = 0;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cy_out,
    output logic         hc_out,
    output logic         ov_out
);
    localparam int HALF = W / 2;

    logic [W-1:0] b_eff;
    logic [W:0]   carry;

    assign b_eff    = sub ? ~b : b;
    assign carry[0] = sub ? ~cin : cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
    end

    // in subtract mode a missing carry means a borrow
    assign cy_out = carry[W] ^ sub;
    assign hc_out = carry[HALF] ^ sub;
    assign ov_out = carry[W] ^ carry[W-1];
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] part [0:W];

    assign part[0] = '0;
    for (genvar i = 0; i < W; i++) begin : g_row
        logic [PW-1:0] row;
        assign row       = {{W{1'b0}}, (a & {W{b[i]}})} << i;
        assign part[i+1] = part[i] + row;
    end
    assign prod = part[W];
endmodule

// File: rtl/alu8_div.sv
module alu8_div #(
    parameter int W = 8
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    logic [W-1:0] r [0:W];

    assign r[0] = '0;
    for (genvar k = 0; k < W; k++) begin : g_stage
        localparam int BI = W - 1 - k;
        logic [W:0] trial;
        logic [W:0] diff;
        assign trial    = {r[k], dividend[BI]};
        assign diff     = trial - {1'b0, divisor};
        assign quot[BI] = ~diff[W];
        assign r[k+1]   = diff[W] ? trial[W-1:0] : diff[W-1:0];
    end
    assign rem = r[W];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [2:0]   op,
    input  logic         use_imm,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] imm_in,
    input  logic [W-1:0] psw_in,
    output logic         out_valid,
    output logic [W-1:0] acc_out,
    output logic [W-1:0] b_out,
    output logic [W-1:0] psw_out
);
    logic [W-1:0]   operand;
    logic           as_sub;
    logic           as_cin;
    logic [W-1:0]   as_sum;
    logic           as_cy, as_hc, as_ov;
    logic [2*W-1:0] mul_p;
    logic [W-1:0]   div_q, div_r;
    logic           div_zero;

    logic [W-1:0] acc_nx, b_nx, psw_nx;

    assign operand  = use_imm ? imm_in : b_in;
    assign as_sub   = (op == OP_SUBB);
    assign as_cin   = (op == OP_ADD) ? 1'b0 : psw_in[ST_CY];
    assign div_zero = (b_in == '0);

    alu8_addsub #(.W(W)) u_addsub (
        .a      (acc_in),
        .b      (operand),
        .cin    (as_cin),
        .sub    (as_sub),
        .sum    (as_sum),
        .cy_out (as_cy),
        .hc_out (as_hc),
        .ov_out (as_ov)
    );

    alu8_mul #(.W(W)) u_mul (
        .a    (acc_in),
        .b    (b_in),
        .prod (mul_p)
    );

    alu8_div #(.W(W)) u_div (
        .dividend (acc_in),
        .divisor  (b_in),
        .quot     (div_q),
        .rem      (div_r)
    );

    always_comb begin
        acc_nx = acc_in;
        b_nx   = b_in;
        psw_nx = psw_in;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                acc_nx         = as_sum;
                psw_nx[ST_CY]  = as_cy;
                psw_nx[ST_HC]  = as_hc;
                psw_nx[ST_OV]  = as_ov;
                psw_nx[ST_PAR] = ^as_sum;
            end
            OP_MUL: begin
                acc_nx         = mul_p[W-1:0];
                b_nx           = mul_p[2*W-1:W];
                psw_nx[ST_CY]  = 1'b0;
                psw_nx[ST_OV]  = (mul_p[2*W-1:W] != '0);
                psw_nx[ST_PAR] = ^mul_p[W-1:0];
            end
            OP_DIV: begin
                psw_nx[ST_CY] = 1'b0;
                psw_nx[ST_OV] = div_zero;
                if (!div_zero) begin
                    acc_nx = div_q;
                    b_nx   = div_r;
                end
                psw_nx[ST_PAR] = div_zero ? ^acc_in : ^div_q;
            end
            default: begin
                acc_nx = acc_in;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            acc_out   <= '0;
            b_out     <= '0;
            psw_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_out <= acc_nx;
                b_out   <= b_nx;
                psw_out <= psw_nx;
            end
        end
    end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [2:0]   op,
    input logic [W-1:0] acc_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] psw_in,
    input logic         out_valid,
    input logic [W-1:0] acc_out,
    input logic [W-1:0] b_out,
    input logic [W-1:0] psw_out
);
    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(acc_out) && $stable(b_out) && $stable(psw_out) && !out_valid));

    // R10
    soft_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (psw_out[5:3] == $past(psw_in[5:3]) && psw_out[1] == $past(psw_in[1])));

    // R6
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) <= 3'd4) |-> (psw_out[ST_PAR] == ^acc_out));

    // R7
    mul_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == OP_MUL) |->
            ({b_out, acc_out} == $past(acc_in) * $past(b_in) && !psw_out[ST_CY]));

    // R9
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == OP_DIV && $past(b_in) == '0) |->
            (acc_out == $past(acc_in) && b_out == '0 && psw_out[ST_OV] && !psw_out[ST_CY]));
endmodule

bind alu8_core alu8_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .acc_in    (acc_in),
    .b_in      (b_in),
    .psw_in    (psw_in),
    .out_valid (out_valid),
    .acc_out   (acc_out),
    .b_out     (b_out),
    .psw_out   (psw_out)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] op = '0;
    logic       use_imm = 1'b0;
    logic [7:0] acc_in = '0, b_in = '0, imm_in = '0, psw_in = '0;
    logic       out_valid;
    logic [7:0] acc_out, b_out, psw_out;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_imm(use_imm),
        .acc_in(acc_in), .b_in(b_in), .imm_in(imm_in), .psw_in(psw_in),
        .out_valid(out_valid), .acc_out(acc_out), .b_out(b_out), .psw_out(psw_out)
    );

    function automatic int sgn(logic [7:0] v);
        return (v > 8'd127) ? int'({24'b0, v}) - 256 : int'({24'b0, v});
    endfunction

    function automatic logic [23:0] model(logic [2:0] o, logic ui, logic [7:0] a,
                                          logic [7:0] b, logic [7:0] im, logic [7:0] ps);
        logic [7:0] na = a, nb = b, np = ps, opd;
        int c, s, sv, p;
        opd = ui ? im : b;
        c = (o == 3'd0) ? 0 : int'({31'b0, ps[7]});
        case (o)
            3'd0, 3'd1: begin
                s = int'({24'b0, a}) + int'({24'b0, opd}) + c;
                na = s[7:0];
                np[7] = (s > 255);
                np[6] = (int'({28'b0, a[3:0]}) + int'({28'b0, opd[3:0]}) + c > 15);
                sv = sgn(a) + sgn(opd) + c;
                np[2] = (sv > 127 || sv < -128);
            end
            3'd2: begin
                s = int'({24'b0, a}) - int'({24'b0, opd}) - c;
                na = s[7:0];
                np[7] = (s < 0);
                np[6] = (int'({28'b0, a[3:0]}) - int'({28'b0, opd[3:0]}) - c < 0);
                sv = sgn(a) - sgn(opd) - c;
                np[2] = (sv > 127 || sv < -128);
            end
            3'd3: begin
                p = int'({24'b0, a}) * int'({24'b0, b});
                na = p[7:0];
                nb = p[15:8];
                np[7] = 1'b0;
                np[2] = (p > 255);
            end
            3'd4: begin
                np[7] = 1'b0;
                np[2] = (b == 8'd0);
                if (b != 8'd0) begin
                    na = a / b;
                    nb = a % b;
                end
            end
            default: ;
        endcase
        if (o <= 3'd4) np[0] = ^na;
        return {na, nb, np};
    endfunction

    function automatic string tag_of(logic [2:0] o, logic [7:0] b);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R7";
            3'd4: return (b == 8'd0) ? "R9" : "R8";
            default: return "R13";
        endcase
    endfunction

    task automatic check(string tag, logic [23:0] got, logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got A=%h B=%h S=%h expected A=%h B=%h S=%h",
                     tag, got[23:16], got[15:8], got[7:0], exp[23:16], exp[15:8], exp[7:0]);
        end
    endtask

    // called at a negedge; drives request, checks at next negedge
    task automatic run(logic [2:0] o, logic ui, logic [7:0] a, logic [7:0] b,
                       logic [7:0] im, logic [7:0] ps, string tag);
        logic [23:0] exp;
        op = o; use_imm = ui; acc_in = a; b_in = b; imm_in = im; psw_in = ps;
        in_valid = 1'b1;
        exp = model(o, ui, a, b, im, ps);
        @(negedge clk);
        check(tag, {acc_out, b_out, psw_out}, exp);
        check("R12", {23'b0, out_valid}, 24'd1);
    endtask

    initial begin
        logic [23:0] held;
        int dummy;
        dummy = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", {acc_out, b_out, psw_out}, 24'd0);
        check("R12", {23'b0, out_valid}, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R5: 0x7F+1 signed overflow, half-carry (R4)
        run(3'd0, 1'b0, 8'h7F, 8'h01, 8'h00, 8'h00, "R5");
        // R2/R4: 0x0F+0+carry gives half-carry
        run(3'd1, 1'b0, 8'h0F, 8'h00, 8'h00, 8'h80, "R4");
        // R1: carry out, ADD ignores incoming carry
        run(3'd0, 1'b0, 8'hFF, 8'h01, 8'h00, 8'h80, "R1");
        // R3/R5: 0x80-1 overflow
        run(3'd2, 1'b0, 8'h80, 8'h01, 8'h00, 8'h00, "R5");
        // R3/R4: borrow chain with incoming borrow
        run(3'd2, 1'b0, 8'h10, 8'h00, 8'h00, 8'h80, "R4");
        run(3'd2, 1'b0, 8'h00, 8'h00, 8'h00, 8'h80, "R3");
        // R11: immediate selected for add, ignored by multiply
        run(3'd0, 1'b1, 8'h10, 8'h55, 8'h22, 8'h00, "R11");
        run(3'd3, 1'b1, 8'h10, 8'h10, 8'hFF, 8'h00, "R11");
        // R7 boundaries
        run(3'd3, 1'b0, 8'd15, 8'd17, 8'h00, 8'h80, "R7");
        run(3'd3, 1'b0, 8'd16, 8'd16, 8'h00, 8'h00, "R7");
        run(3'd3, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'h80, "R7");
        // R8/R9
        run(3'd4, 1'b0, 8'd200, 8'd7, 8'h00, 8'hA4, "R8");
        run(3'd4, 1'b0, 8'd93, 8'd0, 8'h00, 8'h80, "R9");
        // R10: soft bits and half-carry kept by mul/div
        run(3'd4, 1'b0, 8'd9, 8'd3, 8'h00, 8'h7A, "R10");
        run(3'd3, 1'b1, 8'd3, 8'd5, 8'h00, 8'h7A, "R10");
        // R13: reserved codes
        run(3'd5, 1'b0, 8'h3C, 8'hC3, 8'h11, 8'hFF, "R13");
        run(3'd7, 1'b1, 8'h01, 8'h02, 8'h03, 8'h5A, "R13");

        // R12: hold while in_valid low, inputs changing
        held = {acc_out, b_out, psw_out};
        in_valid = 1'b0; op = 3'd0; acc_in = 8'hAA; b_in = 8'h77;
        @(negedge clk);
        check("R12", {acc_out, b_out, psw_out}, held);
        check("R12", {23'b0, out_valid}, 24'd0);

        // random stream; R6 parity is part of every compared status byte
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] o;
            logic [7:0] a, b, im, ps;
            o  = 3'($urandom_range(0, 7));
            a  = 8'($urandom);
            b  = 8'($urandom);
            im = 8'($urandom);
            ps = 8'($urandom);
            if ($urandom_range(0, 3) == 0) b = 8'($urandom_range(0, 3));
            run(o, 1'($urandom), a, b, im, ps, tag_of(o, b));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule